// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt-control slice of a multi-cycle processor control unit with a 32-bit datapath. It owns the program counter, a kernel return register and a single interrupt-enable bit. Each time the surrounding control unit begins an instruction fetch, it raises `fetchReq`. The block then decides whether the fetch goes ahead at once or whether an interrupt is taken first.

An interrupt is taken only when the device request is pending and the enable bit is set. Entry runs as a fixed sequence. The current PC is copied into the kernel return register and the enable bit is cleared. The device is then acknowledged, and in the following cycle the device index is captured from the shared bus. The block reads the vector word at that index from a table that starts at memory address 0, waits one cycle for the synchronous read data, and loads the word into the PC. Only then is the fetch released.

Outside a sequence, the block carries out three operations: enable-interrupt, disable-interrupt and return-from-interrupt. It also accepts plain PC writes from the rest of the datapath. The kernel return register can be written through the ordinary register-select field when that field holds the kernel code.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, `pc` is 0x00000010, `intEn` is 0, `kRet` is 0, and `irqAck`, `memRd` and `busy` are 0.
- R2: A pulse on `opEi` in an idle cycle without `fetchReq` sets `intEn` to 1 on the next edge. A pulse on `opDi` clears it to 0; if both are pulsed together, `opDi` wins.
- R3: When `fetchReq` is high in an idle cycle and the interrupt is not both pending and enabled, `fetchGo` is high in that same cycle. In that case `pc` and `kRet` are unchanged and `irqAck` stays low.
- R4: A request that is pending while `intEn` is 0 is not taken and stays pending. It is taken at the first fetch after `intEn` is set.
- R5: When an interrupt is taken, `kRet` holds the value `pc` had at `fetchReq`.
- R6: Taking an interrupt clears `intEn`.
- R7: On a taken interrupt, `irqAck` is high for exactly one cycle, the second cycle after the `fetchReq` cycle. `busIdx` is sampled in the cycle after the acknowledge.
- R8: The block reads the vector word at address 0 + index with `memRd`, with one cycle of read latency. It loads that word into `pc` and raises `fetchGo` six cycles after the `fetchReq` cycle.
- R9: A pulse on `opReti` in an idle cycle loads `pc` from `kRet` and sets `intEn` to 1.
- R10: `regWrEn` with `regSel` equal to 13 (the kernel code) writes `regWrData` into `kRet`. Any other `regSel` value leaves `kRet` unchanged.
- R11: While `busy` is high, the operation inputs, `pcWrEn` and `regWrEn` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Start of an instruction fetch |
| opEi | input | 1 | Enable-interrupt operation |
| opDi | input | 1 | Disable-interrupt operation |
| opReti | input | 1 | Return-from-interrupt operation |
| pcWrEn | input | 1 | Ordinary PC write |
| pcWrData | input | 32 | PC write value |
| regWrEn | input | 1 | Register-file write strobe |
| regSel | input | 4 | Register-select field |
| regWrData | input | 32 | Register write value |
| irqPending | input | 1 | Device interrupt request, held until acknowledged |
| irqAck | output | 1 | Interrupt acknowledge to the device |
| busIdx | input | 32 | Shared bus carrying the device index |
| memRd | output | 1 | Vector table read strobe |
| memAddr | output | 32 | Vector table read address |
| memData | input | 32 | Read data, valid one cycle after `memRd` |
| pc | output | 32 | Program counter |
| kRet | output | 32 | Kernel return register |
| intEn | output | 1 | Interrupt-enable bit |
| fetchGo | output | 1 | Fetch may proceed from `pc` |
| busy | output | 1 | Entry sequence in progress |

## Verification
A wrong enable bit shows up at the next fetch: `fetchGo` either arrives in the request cycle when a six-cycle entry was due, or arrives late when it should not. A corrupted saved PC or vector index stays hidden until the PC is loaded. It then shows as a wrong `pc` at `fetchGo`, or later as a wrong `pc` after the return operation. Errors in the acknowledge timing appear at the ports within two cycles of the request, as a misplaced or stretched `irqAck`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_ACK, ST_IDX, ST_READ, ST_WAIT, ST_FETCH
  } seqState_t;

  typedef struct packed {
    logic saveK;
    logic clrIe;
    logic setIe;
    logic capIdx;
    logic loadVec;
    logic retPc;
    logic hostPcWr;
    logic hostK0Wr;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] K0_SEL = 4'd13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic             opEi,
  input  logic             opDi,
  input  logic             opReti,
  input  logic             pcWrEn,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic             irqPending,
  input  logic             intEn,
  output ctrlStrobes_t     strb,
  output logic             irqAck,
  output logic             memRd,
  output logic             fetchGo,
  output logic             busy
);
  seqState_t state, stateNext;
  logic take;

  assign take = fetchReq && irqPending && intEn;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    irqAck    = 1'b0;
    memRd     = 1'b0;
    fetchGo   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fetchReq) begin
          if (take) stateNext = ST_SAVE;
          else      fetchGo   = 1'b1;
        end else begin
          strb.setIe    = (opEi || opReti) && !opDi;
          strb.clrIe    = opDi;
          strb.retPc    = opReti;
          strb.hostPcWr = pcWrEn;
          strb.hostK0Wr = regWrEn && (regSel == K0_SEL);
        end
      end
      ST_SAVE: begin
        strb.saveK = 1'b1;
        strb.clrIe = 1'b1;
        stateNext  = ST_ACK;
      end
      ST_ACK: begin
        irqAck    = 1'b1;
        stateNext = ST_IDX;
      end
      ST_IDX: begin
        strb.capIdx = 1'b1;
        stateNext   = ST_READ;
      end
      ST_READ: begin
        memRd     = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        strb.loadVec = 1'b1;
        stateNext    = ST_FETCH;
      end
      ST_FETCH: begin
        fetchGo   = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R7: acknowledge lasts one cycle and the index capture follows it
  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (!irqAck && strb.capIdx));

  // R8: read data is consumed one cycle after the read strobe
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> (strb.loadVec && !memRd));

  // R11: host strobes never issue during a sequence
  assert_host_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.hostPcWr || strb.hostK0Wr || strb.retPc || strb.setIe));
endmodule

// File: rtl/irq_seq_dpath.sv
module irq_seq_dpath
  import irq_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] RESET_PC = 32'h0000_0010,
  parameter logic [DW-1:0] VEC_BASE = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strb,
  input  logic [DW-1:0] pcWrData,
  input  logic [DW-1:0] regWrData,
  input  logic [DW-1:0] busIdx,
  input  logic [DW-1:0] memData,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] kRet,
  output logic          intEn
);
  logic [DW-1:0] idxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= RESET_PC;
      kRet   <= '0;
      intEn  <= 1'b0;
      idxReg <= '0;
    end else begin
      if (strb.loadVec)       pc <= memData;
      else if (strb.retPc)    pc <= kRet;
      else if (strb.hostPcWr) pc <= pcWrData;

      if (strb.saveK)         kRet <= pc;
      else if (strb.hostK0Wr) kRet <= regWrData;

      if (strb.clrIe)      intEn <= 1'b0;
      else if (strb.setIe) intEn <= 1'b1;

      if (strb.capIdx) idxReg <= busIdx;
    end
  end

  assign memAddr = VEC_BASE + idxReg;

  // R5: saved PC is the PC seen in the save cycle
  assert_save_pc_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveK |=> (kRet == $past(pc)));

  // R6: entry leaves interrupts disabled
  assert_entry_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveK |=> !intEn);

  // R8: vector word lands in the PC
  assert_vector_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadVec |=> (pc == $past(memData)));

  // R9: return restores PC and enables interrupts
  assert_return_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retPc && !strb.clrIe) |=> (intEn && pc == $past(kRet)));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] K0_SEL = 4'd13,
  parameter logic [DW-1:0] RESET_PC = 32'h0000_0010,
  parameter logic [DW-1:0] VEC_BASE = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic             opEi,
  input  logic             opDi,
  input  logic             opReti,
  input  logic             pcWrEn,
  input  logic [DW-1:0]    pcWrData,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [DW-1:0]    regWrData,
  input  logic             irqPending,
  output logic             irqAck,
  input  logic [DW-1:0]    busIdx,
  output logic             memRd,
  output logic [DW-1:0]    memAddr,
  input  logic [DW-1:0]    memData,
  output logic [DW-1:0]    pc,
  output logic [DW-1:0]    kRet,
  output logic             intEn,
  output logic             fetchGo,
  output logic             busy
);
  ctrlStrobes_t strb;

  irq_seq_ctrl #(.SEL_W(SEL_W), .K0_SEL(K0_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq),
    .opEi(opEi), .opDi(opDi), .opReti(opReti),
    .pcWrEn(pcWrEn), .regWrEn(regWrEn), .regSel(regSel),
    .irqPending(irqPending), .intEn(intEn),
    .strb(strb), .irqAck(irqAck), .memRd(memRd),
    .fetchGo(fetchGo), .busy(busy)
  );

  irq_seq_dpath #(.DW(DW), .RESET_PC(RESET_PC), .VEC_BASE(VEC_BASE)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pcWrData(pcWrData), .regWrData(regWrData), .busIdx(busIdx),
    .memData(memData), .memAddr(memAddr),
    .pc(pc), .kRet(kRet), .intEn(intEn)
  );
endmodule

// File: tb/sim_irq_seq_top.sv
`timescale 1ns/1ps
module sim_irq_seq_top;
  logic clk = 1'b0;
  logic rstN;
  logic fetchReq, opEi, opDi, opReti, pcWrEn, regWrEn, irqPending;
  logic [31:0] pcWrData, regWrData, busIdx, memData, memAddr, pc, kRet;
  logic [3:0] regSel;
  logic irqAck, memRd, intEn, fetchGo, busy;

  int nTests = 0;
  int nFail = 0;
  int ackCnt = 0;
  logic drvIdx = 1'b0;
  logic [31:0] devIdx = 32'd1;
  int fetchLat, ackStep, rdStep;
  logic [31:0] rdAddr;

  always #10 clk = ~clk;

  irq_seq_top u0 (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .opEi(opEi), .opDi(opDi),
    .opReti(opReti), .pcWrEn(pcWrEn), .pcWrData(pcWrData), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .irqPending(irqPending),
    .irqAck(irqAck), .busIdx(busIdx), .memRd(memRd), .memAddr(memAddr),
    .memData(memData), .pc(pc), .kRet(kRet), .intEn(intEn),
    .fetchGo(fetchGo), .busy(busy)
  );

  function automatic logic [31:0] vecWord(input logic [31:0] a);
    return 32'h0000_1000 + (a << 4);
  endfunction

  // memory and device models
  always @(posedge clk) begin
    memData <= memRd ? vecWord(memAddr) : 32'h0;
    drvIdx  <= irqAck;
    if (irqAck) ackCnt <= ackCnt + 1;
  end
  assign busIdx = drvIdx ? devIdx : 32'h0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idleOps();
    fetchReq = 0; opEi = 0; opDi = 0; opReti = 0; pcWrEn = 0; regWrEn = 0;
  endtask

  task automatic pulse(input bit ei, input bit di, input bit reti);
    @(negedge clk); opEi = ei; opDi = di; opReti = reti;
    @(negedge clk); idleOps();
  endtask

  task automatic setPc(input logic [31:0] v);
    @(negedge clk); pcWrEn = 1; pcWrData = v;
    @(negedge clk); idleOps();
  endtask

  // returns latency in cycles from fetchReq to fetchGo (0 = same cycle)
  task automatic runFetch(input bit holdEi);
    fetchLat = -1; ackStep = -1; rdStep = -1; rdAddr = 0;
    @(negedge clk); fetchReq = 1; #1;
    if (fetchGo) fetchLat = 0;
    else begin
      @(negedge clk); fetchReq = 0; opEi = holdEi; pcWrEn = holdEi;
      pcWrData = 32'hDEAD_0000; regWrEn = holdEi; regSel = 4'd13;
      regWrData = 32'hBAD0_0000;
      for (int n = 1; n < 12; n++) begin
        #1;
        if (irqAck && ackStep < 0) ackStep = n;
        if (memRd) begin rdStep = n; rdAddr = memAddr; end
        if (fetchGo) begin fetchLat = n; break; end
        @(negedge clk);
      end
    end
    @(negedge clk); idleOps();
  endtask

  typedef struct packed {
    logic        ie;
    logic        pend;
    logic [31:0] idx;
    logic [31:0] startPc;
    logic        taken;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 32'd1, 32'h0000_0040, 1'b1},
    '{1'b1, 1'b0, 32'd1, 32'h0000_0080, 1'b0},
    '{1'b0, 1'b1, 32'd2, 32'h0000_00C4, 1'b0},
    '{1'b1, 1'b1, 32'd3, 32'h0000_1234, 1'b1},
    '{1'b1, 1'b1, 32'd7, 32'h00AB_CDEF, 1'b1},
    '{1'b0, 1'b0, 32'd0, 32'h0000_0010, 1'b0}
  };

  initial begin
    #400000;
    nFail++; nTests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int a0;
    idleOps(); irqPending = 0; pcWrData = 0; regWrData = 0; regSel = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check(pc == 32'h10, "R1 pc", pc, 32'h10);
    check(!intEn && !irqAck && !memRd && !busy, "R1 ctrl outs", {intEn, irqAck, memRd, busy}, 0);
    check(kRet == 0, "R1 kRet", kRet, 0);

    // R2 enable/disable
    pulse(1, 0, 0); check(intEn == 1, "R2 EI", intEn, 1);
    pulse(0, 1, 0); check(intEn == 0, "R2 DI", intEn, 0);
    pulse(1, 1, 0); check(intEn == 0, "R2 DI wins", intEn, 0);

    // table walk: R3 R5 R6 R7 R8
    foreach (VECS[i]) begin
      setPc(VECS[i].startPc);
      pulse(VECS[i].ie, !VECS[i].ie, 0);
      irqPending = VECS[i].pend; devIdx = VECS[i].idx;
      a0 = ackCnt;
      runFetch(0);
      if (VECS[i].taken) begin
        check(fetchLat == 6, "R8 latency", fetchLat, 6);
        check(ackStep == 2 && ackCnt - a0 == 1, "R7 ack", ackStep, 2);
        check(rdAddr == VECS[i].idx && rdStep == 4, "R8 vec addr", rdAddr, VECS[i].idx);
        check(pc == vecWord(VECS[i].idx), "R8 pc", pc, vecWord(VECS[i].idx));
        check(kRet == VECS[i].startPc, "R5 kRet", kRet, VECS[i].startPc);
        check(intEn == 0, "R6 ie cleared", intEn, 0);
        irqPending = 0;
      end else begin
        check(fetchLat == 0, "R3 no entry", fetchLat, 0);
        check(pc == VECS[i].startPc, "R3 pc kept", pc, VECS[i].startPc);
        check(ackCnt == a0, "R3 no ack", ackCnt - a0, 0);
      end
    end

    // R4 pending while disabled, then enabled
    irqPending = 1; devIdx = 32'd5; setPc(32'h300);
    pulse(0, 1, 0);
    runFetch(0);
    check(fetchLat == 0 && pc == 32'h300, "R4 held off", pc, 32'h300);
    pulse(1, 0, 0);
    runFetch(0);
    check(fetchLat == 6 && pc == vecWord(5), "R4 taken after EI", pc, vecWord(5));
    irqPending = 0;

    // R9 return
    pulse(0, 0, 1);
    check(pc == 32'h300, "R9 pc from kRet", pc, 32'h300);
    check(intEn == 1, "R9 ie set", intEn, 1);

    // R10 kRet via register select
    @(negedge clk); regWrEn = 1; regSel = 4'd12; regWrData = 32'h5555;
    @(negedge clk); idleOps();
    check(kRet == 32'h300, "R10 other sel ignored", kRet, 32'h300);
    @(negedge clk); regWrEn = 1; regSel = 4'd13; regWrData = 32'h7777;
    @(negedge clk); idleOps();
    check(kRet == 32'h7777, "R10 k0 write", kRet, 32'h7777);

    // R11 inputs ignored while busy (intEn is 1 here)
    irqPending = 1; devIdx = 32'd2; setPc(32'h440);
    runFetch(1);
    check(intEn == 0, "R11 EI ignored", intEn, 0);
    check(pc == vecWord(2), "R11 pc write ignored", pc, vecWord(2));
    check(kRet == 32'h440, "R11 k0 write ignored", kRet, 32'h440);
    irqPending = 0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule